// File: doc/BRIEF.md
# Serial Frame Sync Generator

This block produces the frame synchronisation signal for one direction of a synchronous serial port. It advances once per bit time, on a bit-clock enable, and takes all its settings from plain configuration inputs. These settings are the waveform kind, the sync length, the period divider, the start delay and data-window length, the tag enable and the edge polarity. It starts frames on its own at a programmed rate, or on an external request when the divider is zero. Each frame start is marked with a one-cycle strobe.

While the sync pulse is active, the block can carry a short tag of the same length as the pulse. It drives the transmit tag MSB first on a dedicated serial output, and it assembles the incoming tag from the receive line. A tag needs the whole pulse to finish before normal data begins. If the pulse would run into the normal data, the main data path takes priority. In that case the block does not shift the tag itself. It hands the captured tag word to the main shifter with a strobe. A sticky flag records the chosen edge of the sync pin.

Every tag transfer happens at a fixed bit time, so no data interface has back-pressure. The hand-off strobe and the done strobe each last one clock. The consumer must take the word in that cycle. The tag source must hold `tag_tx` steady at each frame start.

Top module: `fsync_gen`

## Requirements
- R1: Pulse modes. Mode 2 drives the pin high and mode 1 drives it low, for `cfg_len`+1 bit times starting at the frame start. Outside the pulse, the pin rests at the opposite level.
- R2: Level modes. The data window starts `cfg_dly` bit times after the frame start and lasts `cfg_dlen`+1 bit times. Mode 4 drives the pin high during this window and mode 3 drives it low; outside the window the pin rests at the opposite level.
- R3: Mode 5 inverts the pin at every frame start, starting from low after reset. Mode 0 and the unused codes 6 and 7 hold the pin low.
- R4: With `cfg_period` non-zero, a frame starts every 2×(`cfg_period`+1) bit times. The first frame starts on the first bit tick after reset. Each start gives a one-clock `sof` pulse in the clock after that tick.
- R5: With `cfg_period` zero, a frame starts only on a bit tick where `start_req` is high.
- R6: When `cfg_sden` is high and `cfg_len` < `cfg_dly`, `sd_out` carries bit `cfg_len`−k of the tag captured at the frame start during pulse bit k, so the MSB goes first. In all other cases `sd_out` is low.
- R7: When `cfg_len` < `cfg_dly`, `rx_line` is sampled at the end of each pulse bit time. After the last pulse bit, `tag_done` pulses for one clock. At that point `rx_tag` holds the `cfg_len`+1 received bits with the first bit as MSB, and the upper bits are zero.
- R8: When `cfg_len` >= `cfg_dly` and `cfg_sden` is high, no tag is shifted and `tag_done` stays low. Instead, `handoff_valid` pulses with `sof`, and `handoff_tag` carries the `tag_tx` value captured at that frame start.
- R9: The `sync_flag` output sets on a pin edge: rising when `cfg_edge_rise` is 1, falling when it is 0. It stays set until `flag_clr` is high. If both happen in the same clock, the set wins.
- R10: While `bit_en` is low, the pin, the frame position and the tag state do not advance.
- R11: During reset, `sof`, `sd_out`, `tag_done`, `handoff_valid` and `sync_flag` are low, and no frame is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One-clock tick per bit time |
| cfg_mode | input | 3 | Pin waveform kind (0..5) |
| cfg_len | input | 4 | Sync/tag length minus one |
| cfg_period | input | 8 | Period divider; 0 = request-driven |
| cfg_dly | input | 8 | Bit times from frame start to data |
| cfg_dlen | input | 5 | Data window length minus one |
| cfg_sden | input | 1 | Enable for transmit tag |
| cfg_edge_rise | input | 1 | 1 = flag rising edges, 0 = falling |
| start_req | input | 1 | External frame start request |
| flag_clr | input | 1 | Clears the sticky flag |
| tag_tx | input | 16 | Transmit tag, captured at frame start |
| rx_line | input | 1 | Serial receive data |
| fs_pin | output | 1 | Frame sync pin |
| sof | output | 1 | Frame start strobe |
| sd_out | output | 1 | Serial tag output |
| rx_tag | output | 16 | Received tag |
| tag_done | output | 1 | Tag finished strobe |
| handoff_valid | output | 1 | Tag handed to main shifter |
| handoff_tag | output | 16 | Tag word for main shifter |
| sync_flag | output | 1 | Sticky edge flag |

## Verification
The assertions assume that the configuration inputs change only while reset is held. Several of them relate a strobe to a tick one clock earlier, and the hand-off property depends on the tag-overlap test not changing between a start and the next tick. The bench follows this rule: it loads each configuration during reset and then leaves it alone. It drives `bit_en` on alternate clocks, with stalls, and pulses `flag_clr` on a fixed pattern that sometimes coincides with pin edges.

// File: rtl/fsync_pkg.sv
package fsync_pkg;
  typedef enum logic [2:0] {
    FS_NONE      = 3'd0,
    FS_NEG_PULSE = 3'd1,
    FS_POS_PULSE = 3'd2,
    FS_LOW_DATA  = 3'd3,
    FS_HIGH_DATA = 3'd4,
    FS_TOGGLE    = 3'd5
  } fs_mode_e;
endpackage

// File: rtl/fsync_timer.sv
module fsync_timer #(
  parameter int unsigned PER_W = 8,
  parameter int unsigned POS_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic [PER_W-1:0] cfg_period,
  input  logic             start_req,
  output logic             start_now,
  output logic [POS_W-1:0] pos,
  output logic             sof,
  output logic             tog
);
  localparam int unsigned PC_W = PER_W + 1;
  localparam logic [POS_W-1:0] POS_IDLE = '1;

  logic [PC_W-1:0] pcnt;
  logic            periodic;

  assign periodic  = |cfg_period;
  assign start_now = bit_en & (periodic ? (pcnt == '0) : start_req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0;
      pos  <= POS_IDLE;
      sof  <= 1'b0;
      tog  <= 1'b0;
    end else begin
      sof <= start_now;
      if (bit_en) begin
        if (periodic) pcnt <= (pcnt == '0) ? {cfg_period, 1'b1} : pcnt - 1'b1;
        else          pcnt <= '0;
        if (start_now)             pos <= '0;
        else if (pos != POS_IDLE)  pos <= pos + 1'b1;
        if (start_now) tog <= ~tog;
      end
    end
  end

  // R4: a start strobe always follows a bit tick
  p_sof_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sof |-> $past(bit_en));
  // R10: no bit tick, no movement of the frame position
  p_pos_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(pos));
endmodule

// File: rtl/fsync_wave.sv
module fsync_wave
  import fsync_pkg::*;
#(
  parameter int unsigned LEN_W  = 4,
  parameter int unsigned DLY_W  = 8,
  parameter int unsigned DLEN_W = 5,
  parameter int unsigned POS_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cfg_mode,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic [DLY_W-1:0]  cfg_dly,
  input  logic [DLEN_W-1:0] cfg_dlen,
  input  logic              cfg_edge_rise,
  input  logic              flag_clr,
  input  logic [POS_W-1:0]  pos,
  input  logic              tog,
  output logic              fs_pin,
  output logic              sync_flag
);
  logic             pulse_on, data_on, pin_d, armed, set_ev;
  logic [POS_W-1:0] win_end;
  fs_mode_e         mode;

  assign mode     = fs_mode_e'(cfg_mode);
  assign pulse_on = pos <= POS_W'(cfg_len);
  assign win_end  = POS_W'(cfg_dly) + POS_W'(cfg_dlen);
  assign data_on  = (pos >= POS_W'(cfg_dly)) && (pos <= win_end);

  always_comb begin
    unique case (mode)
      FS_NEG_PULSE: fs_pin = ~pulse_on;
      FS_POS_PULSE: fs_pin = pulse_on;
      FS_LOW_DATA:  fs_pin = ~data_on;
      FS_HIGH_DATA: fs_pin = data_on;
      FS_TOGGLE:    fs_pin = tog;
      default:      fs_pin = 1'b0;
    endcase
  end

  assign set_ev = armed & (cfg_edge_rise ? (fs_pin & ~pin_d) : (~fs_pin & pin_d));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_d     <= 1'b0;
      armed     <= 1'b0;
      sync_flag <= 1'b0;
    end else begin
      pin_d <= fs_pin;
      armed <= 1'b1;
      if (set_ev)        sync_flag <= 1'b1;
      else if (flag_clr) sync_flag <= 1'b0;
    end
  end

  // R9: flag holds until cleared
  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sync_flag && !flag_clr |=> sync_flag);
  // R9: a coincident set beats the clear
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev && flag_clr |=> sync_flag);
endmodule

// File: rtl/fsync_tag.sv
module fsync_tag #(
  parameter int unsigned TAG_W = 16,
  parameter int unsigned LEN_W = 4,
  parameter int unsigned DLY_W = 8,
  parameter int unsigned POS_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             start_now,
  input  logic [POS_W-1:0] pos,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic [DLY_W-1:0] cfg_dly,
  input  logic             cfg_sden,
  input  logic [TAG_W-1:0] tag_tx,
  input  logic             rx_line,
  output logic             sd_out,
  output logic [TAG_W-1:0] rx_tag,
  output logic             tag_done,
  output logic             handoff_valid,
  output logic [TAG_W-1:0] handoff_tag
);
  localparam int unsigned CMP_W = DLY_W + 1;

  logic [TAG_W-1:0] hold, rx_sr, mask;
  logic [LEN_W-1:0] idx;
  logic             fits, in_win;

  assign fits   = CMP_W'(cfg_len) < CMP_W'(cfg_dly);
  assign in_win = pos <= POS_W'(cfg_len);
  assign idx    = cfg_len - pos[LEN_W-1:0];
  assign sd_out = cfg_sden & fits & in_win & hold[idx];

  for (genvar i = 0; i < TAG_W; i++) begin : g_mask
    assign mask[i] = LEN_W'(i) <= cfg_len;
  end

  assign rx_tag      = rx_sr & mask;
  assign handoff_tag = hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold          <= '0;
      rx_sr         <= '0;
      tag_done      <= 1'b0;
      handoff_valid <= 1'b0;
    end else begin
      tag_done      <= 1'b0;
      handoff_valid <= start_now & cfg_sden & ~fits;
      if (start_now) hold <= tag_tx;
      if (bit_en && fits && in_win) begin
        rx_sr    <= {rx_sr[TAG_W-2:0], rx_line};
        tag_done <= pos == POS_W'(cfg_len);
      end
    end
  end

  // R7: completion only at the end of a bit time
  p_done_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tag_done |-> $past(bit_en));
  // R8: hand-off and local shifting never both complete
  p_no_mix_r8: assert property (@(posedge clk) disable iff (!rst_n)
    handoff_valid |-> !tag_done);
endmodule

// File: rtl/fsync_gen.sv
module fsync_gen #(
  parameter int unsigned TAG_W  = 16,
  parameter int unsigned PER_W  = 8,
  parameter int unsigned DLY_W  = 8,
  parameter int unsigned DLEN_W = 5,
  parameter int unsigned POS_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic [2:0]        cfg_mode,
  input  logic [$clog2(TAG_W)-1:0] cfg_len,
  input  logic [PER_W-1:0]  cfg_period,
  input  logic [DLY_W-1:0]  cfg_dly,
  input  logic [DLEN_W-1:0] cfg_dlen,
  input  logic              cfg_sden,
  input  logic              cfg_edge_rise,
  input  logic              start_req,
  input  logic              flag_clr,
  input  logic [TAG_W-1:0]  tag_tx,
  input  logic              rx_line,
  output logic              fs_pin,
  output logic              sof,
  output logic              sd_out,
  output logic [TAG_W-1:0]  rx_tag,
  output logic              tag_done,
  output logic              handoff_valid,
  output logic [TAG_W-1:0]  handoff_tag,
  output logic              sync_flag
);
  localparam int unsigned LEN_W = $clog2(TAG_W);

  logic             start_now, tog;
  logic [POS_W-1:0] pos;

  fsync_timer #(.PER_W(PER_W), .POS_W(POS_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .cfg_period(cfg_period),
    .start_req(start_req), .start_now(start_now), .pos(pos), .sof(sof), .tog(tog)
  );

  fsync_wave #(.LEN_W(LEN_W), .DLY_W(DLY_W), .DLEN_W(DLEN_W), .POS_W(POS_W)) u_wave (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_len(cfg_len),
    .cfg_dly(cfg_dly), .cfg_dlen(cfg_dlen), .cfg_edge_rise(cfg_edge_rise),
    .flag_clr(flag_clr), .pos(pos), .tog(tog), .fs_pin(fs_pin), .sync_flag(sync_flag)
  );

  fsync_tag #(.TAG_W(TAG_W), .LEN_W(LEN_W), .DLY_W(DLY_W), .POS_W(POS_W)) u_tag (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .start_now(start_now), .pos(pos),
    .cfg_len(cfg_len), .cfg_dly(cfg_dly), .cfg_sden(cfg_sden), .tag_tx(tag_tx),
    .rx_line(rx_line), .sd_out(sd_out), .rx_tag(rx_tag), .tag_done(tag_done),
    .handoff_valid(handoff_valid), .handoff_tag(handoff_tag)
  );
endmodule

// File: tb/sim_fsync_gen.sv
`timescale 1ns/1ps
module sim_fsync_gen;
  localparam int IDLE = 1023;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, bit_en = 1'b0, cfg_sden = 1'b0, cfg_edge_rise = 1'b1;
  logic start_req = 1'b0, flag_clr = 1'b0, rx_line = 1'b0;
  logic [2:0] cfg_mode = '0;
  logic [3:0] cfg_len = '0;
  logic [7:0] cfg_period = 8'd1, cfg_dly = 8'd4;
  logic [4:0] cfg_dlen = '0;
  logic [15:0] tag_tx = '0, rx_pat = '0;
  logic fs_pin, sof, sd_out, tag_done, handoff_valid, sync_flag;
  logic [15:0] rx_tag, handoff_tag;

  fsync_gen u0 (.*);

  int vec = 0, bad = 0, cyc = 0, tagchk = 0;
  logic gen_en = 1'b0, use_req = 1'b0;

  // behavioural reference state
  int m_pc, m_pos, run_len, last_w, last_sof, gap;
  logic m_tog, m_flag, m_armed, m_pind, m_sof, m_done, m_hand;
  logic [15:0] m_hold, m_rx, txcol;

  function automatic logic m_pin();
    logic pl, dw;
    pl = (m_pos <= cfg_len);
    dw = (m_pos >= cfg_dly) && (m_pos <= cfg_dly + cfg_dlen);
    case (cfg_mode)
      3'd1: return !pl;
      3'd2: return pl;
      3'd3: return !dw;
      3'd4: return dw;
      3'd5: return m_tog;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic fits();
    return cfg_len < cfg_dly;
  endfunction

  task automatic model_reset();
    m_pc = 0; m_pos = IDLE; m_tog = 0; m_flag = 0; m_armed = 0; m_pind = 0;
    m_sof = 0; m_done = 0; m_hand = 0; m_hold = '0; m_rx = '0; txcol = '0;
    run_len = 0; last_w = -1; last_sof = -1; gap = -1;
  endtask

  task automatic check(logic ok, string req, string what, int act, int exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      logic p, st;
      p = m_pin();
      if (m_armed && (cfg_edge_rise ? (p && !m_pind) : (!p && m_pind))) m_flag = 1;
      else if (flag_clr) m_flag = 0;
      m_pind = p; m_armed = 1;
      m_sof = 0; m_done = 0; m_hand = 0;
      if (bit_en) begin
        st = (cfg_period != 0) ? (m_pc == 0) : start_req;
        if (cfg_period != 0) m_pc = (m_pc == 0) ? 2 * (cfg_period + 1) - 1 : m_pc - 1;
        else m_pc = 0;
        if (fits() && m_pos <= cfg_len) begin
          m_rx = {m_rx[14:0], rx_line};
          m_done = (m_pos == cfg_len);
        end
        if (st) begin
          m_pos = 0; m_tog = !m_tog; m_hold = tag_tx; m_sof = 1;
          m_hand = cfg_sden && !fits();
        end else if (m_pos < IDLE) m_pos++;
      end
    end
  end

  // stimulus for bit ticks, clears, requests and the receive line
  always @(negedge clk) begin
    cyc++;
    bit_en    = gen_en ? !bit_en : 1'b0;
    flag_clr  = (cyc % 7 == 3);
    start_req = use_req && (cyc % 13 == 0);
    rx_line   = (m_pos <= cfg_len) ? rx_pat[cfg_len - m_pos] : 1'b0;
  end

  always @(negedge clk) begin
    #1;
    if (!rst_n) begin
      model_reset();
      check(!sof && !sd_out && !tag_done && !handoff_valid && !sync_flag,
            "R11", "reset outputs", {sof, sd_out, tag_done, handoff_valid, sync_flag}, 0);
      check(fs_pin === m_pin(), "R11", "idle pin", fs_pin, m_pin());
    end else begin
      logic [15:0] msk, expsd;
      string preq;
      msk = 16'((32'd1 << (cfg_len + 1)) - 1);
      preq = (cfg_mode == 1 || cfg_mode == 2) ? "R1" : (cfg_mode == 3 || cfg_mode == 4) ? "R2" : "R3";
      expsd = (cfg_sden && fits() && m_pos <= cfg_len) ? m_hold[cfg_len - m_pos] : 1'b0;
      check(fs_pin === m_pin(), preq, "fs_pin", fs_pin, m_pin());
      check(sof === m_sof, (cfg_period != 0) ? "R4" : "R5", "sof", sof, m_sof);
      check(sd_out === expsd[0], "R6", "sd_out", sd_out, expsd[0]);
      check(tag_done === m_done && rx_tag === (m_rx & msk), "R7", "rx tag/done",
            {tag_done, rx_tag}, {m_done, m_rx & msk});
      check(handoff_valid === m_hand, "R8", "handoff_valid", handoff_valid, m_hand);
      if (m_hand) check(handoff_tag === m_hold, "R8", "handoff_tag", handoff_tag, m_hold);
      check(sync_flag === m_flag, "R9", "sync_flag", sync_flag, m_flag);
      // width and period measurement
      if ((cfg_mode == 1 || cfg_mode == 3) ? !fs_pin : fs_pin) run_len++;
      else if (run_len > 0) begin last_w = run_len; run_len = 0; end
      if (sof) begin
        if (last_sof >= 0) gap = cyc - last_sof;
        last_sof = cyc;
      end
      // tag content: bits sent/received over one pulse
      if (bit_en && fits() && m_pos <= cfg_len) txcol = {txcol[14:0], sd_out};
      if (tag_done) begin
        tagchk++;
        check(rx_tag === (rx_pat & msk), "R7", "received tag", rx_tag, rx_pat & msk);
        if (cfg_sden) check(txcol === (tag_tx & msk), "R6", "sent tag", txcol, tag_tx & msk);
        txcol = '0;
      end
    end
  end

  task automatic run(int mode, int len, int per, int dly, int dlen, logic sden,
                     logic rise, logic [15:0] tg, logic [15:0] rp, int n);
    @(negedge clk);
    rst_n = 0; gen_en = 0;
    cfg_mode = 3'(mode); cfg_len = 4'(len); cfg_period = 8'(per); cfg_dly = 8'(dly);
    cfg_dlen = 5'(dlen); cfg_sden = sden; cfg_edge_rise = rise; tag_tx = tg; rx_pat = rp;
    repeat (2) @(negedge clk);
    rst_n = 1; gen_en = 1;
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    int t0;
    // R1 positive pulse: 4 bit times wide = 8 clocks, period 2*(4+1) bits = 20 clocks
    run(2, 3, 4, 6, 0, 1, 1, 16'hA5C3, 16'h3C5A, 200);
    check(last_w == 8, "R1", "pos pulse width", last_w, 8);
    check(gap == 20, "R4", "frame period", gap, 20);
    // R1 negative pulse of one bit time, period 8 clocks
    run(1, 0, 1, 4, 0, 0, 0, 16'h0001, 16'h0000, 200);
    check(last_w == 2, "R1", "neg pulse width", last_w, 2);
    check(gap == 8, "R4", "frame period", gap, 8);
    // R2 level modes: window of 4 bit times
    run(3, 1, 5, 2, 3, 0, 1, 16'h0, 16'h0, 240);
    check(last_w == 8, "R2", "low window width", last_w, 8);
    run(4, 1, 5, 2, 3, 0, 0, 16'h0, 16'h0, 240);
    check(last_w == 8, "R2", "high window width", last_w, 8);
    check(gap == 24, "R4", "frame period", gap, 24);
    // R3 toggle: high for one whole frame
    run(5, 0, 2, 4, 0, 0, 1, 16'h0, 16'h0, 200);
    check(last_w == 12, "R3", "toggle high run", last_w, 12);
    run(0, 2, 2, 4, 0, 1, 1, 16'h0, 16'h0, 120);
    // R6/R7 tag lengths 1, 8 and 16
    t0 = tagchk;
    run(2, 0, 15, 20, 0, 1, 1, 16'hFFFF, 16'h0001, 300);
    run(2, 7, 15, 20, 0, 1, 0, 16'hB6D9, 16'h4E71, 300);
    run(2, 15, 15, 20, 0, 1, 1, 16'hC3A7, 16'h9E35, 300);
    check(tagchk - t0 >= 6, "R7", "tag completions seen", tagchk - t0, 6);
    // R6 transmit tag disabled
    run(2, 7, 15, 20, 0, 0, 1, 16'hFFFF, 16'h1234, 200);
    // R8 overlap: sync longer than start delay
    run(2, 7, 10, 3, 0, 1, 1, 16'h5AF0, 16'h1234, 200);
    // R5 request-driven frames
    use_req = 1;
    run(2, 2, 0, 5, 0, 1, 1, 16'h0F0F, 16'h00F5, 300);
    use_req = 0;
    // R10 stall: pin frozen while bit_en is low
    begin
      logic p0;
      run(4, 1, 3, 1, 4, 0, 1, 16'h0, 16'h0, 21);
      gen_en = 0;
      @(negedge clk); #2 p0 = fs_pin;
      repeat (15) @(negedge clk);
      #2 check(fs_pin === p0, "R10", "pin during stall", fs_pin, p0);
      gen_en = 1;
      repeat (60) @(negedge clk);
    end
    finish_up();
  end
endmodule